// File: doc/BRIEF.md
# Radix-2 Carry-Save SRT Divider Datapath

This block divides one normalized binary fraction by another, one signed quotient digit per clock. Both operands have `FRAC_W` fraction bits with the top bit set, so each lies in [1/2, 1), and the dividend must be smaller than the divisor. The partial remainder is held as two two's complement vectors, a sum and a carry, whose arithmetic sum is the remainder. Each step doubles the remainder, estimates it from a handful of leading bits, picks a digit from {-1, 0, +1}, and folds in the matching divisor multiple with a 3:2 compressor. No carry travels the width of the word, so the cycle time does not depend on `FRAC_W`.

A `start` pulse while the block is idle captures the operands. Digits then come out with a strobe on `FRAC_W` consecutive cycles, most significant first. Another block turns them into a binary quotient. After the last digit the block pulses `done` and reports whether the final remainder is negative. That flag needs the only full-width carry-propagate addition in the design. The two remainder vectors stay visible on the ports, so the owner of the quotient can correct it.

Top module: `srt_cs_divider`

## Requirements
- R1: A `start` pulse seen while idle loads the dividend into `rem_sum` and zero into `rem_carry` at that clock edge; `q_valid` stays low in the following cycle.
- R2: Digits are encoded on `q_digit` as 2'b01 = +1, 2'b00 = 0 and 2'b11 = -1; 2'b10 never appears while `q_valid` is high, and `q_digit` reads 2'b00 when `q_valid` is low.
- R3: The estimate is the sum of the shifted (doubled) sum and carry vectors, each truncated below the 1/2 position and added modulo 16 in units of 1/2. The digit is -1 when the estimate is at most -1, 0 when it is exactly -1/2, and +1 when it is 0 or more.
- R4: The vectors are kept modulo 2^(FRAC_W+3) with FRAC_W fraction bits. With each digit, the remainder (rem_sum + rem_carry) becomes twice its previous value minus digit times divisor.
- R5: The remainder stays within [-Y, Y) on every step of a division.
- R6: Exactly FRAC_W digits are produced, on consecutive cycles starting two cycles after the `start` edge.
- R7: `done` is a one-cycle pulse in the cycle after the last digit. At the same time `rem_neg` becomes the sign of rem_sum + rem_carry and holds it until the next division.
- R8: At `done`, the digits satisfy 2^FRAC_W·X = Q·Y + R, with Q the integer weight of the digit string and R the remainder in units of 2^-FRAC_W.
- R9: A `start` pulse during a division is ignored; the running division completes with its original operands.
- R10: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division when idle |
| x_in | input | FRAC_W | Dividend fraction, top bit set |
| y_in | input | FRAC_W | Divisor fraction, top bit set, greater than dividend |
| q_valid | output | 1 | Quotient digit strobe |
| q_digit | output | 2 | Signed quotient digit |
| rem_sum | output | FRAC_W+3 | Partial remainder sum vector |
| rem_carry | output | FRAC_W+3 | Partial remainder carry vector |
| done | output | 1 | One-cycle completion pulse |
| rem_neg | output | 1 | Final remainder is negative |

## Verification
A wrong digit choice or a dropped carry-in shows up in the very next cycle. The reference recomputes the digit from the vectors it saw one cycle earlier, and it checks the new remainder against twice the old one minus the divisor multiple. Because both vectors are on the ports every cycle, a fault in any compressor bit shows as a wrong remainder value on that same step, long before it could distort the quotient. A counter or sequencing fault shows as a digit count other than FRAC_W, as a misplaced `done`, or as a broken division identity at the end.

// File: rtl/srt_pkg.sv
package srt_pkg;

   typedef enum logic [1:0] {
      DIG_ZERO = 2'b00,
      DIG_POS  = 2'b01,
      DIG_NEG  = 2'b11
   } srt_digit_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_RUN  = 2'b01,
      ST_FIN  = 2'b10
   } srt_state_e;

endpackage

// File: rtl/srt_digit_select.sv
module srt_digit_select
   import srt_pkg::*;
#(
   parameter int FRAC_W = 16,
   parameter int VEC_W  = FRAC_W + 3
) (
   input  logic [VEC_W-1:0] dbl_sum,
   input  logic [VEC_W-1:0] dbl_carry,
   output srt_digit_e       digit
);
   // estimate covers the integer bits plus the 1/2 position
   localparam int EST_W = VEC_W - FRAC_W + 1;

   logic [EST_W-1:0] est;

   if (EST_W < 4) begin : g_bad_est
      $error("estimate narrower than 4 bits cannot hold 2R");
   end

   assign est = dbl_sum[VEC_W-1:FRAC_W-1] + dbl_carry[VEC_W-1:FRAC_W-1];

   always_comb begin
      if (!est[EST_W-1])
         digit = DIG_POS;
      else if (est == {EST_W{1'b1}})
         digit = DIG_ZERO;
      else
         digit = DIG_NEG;
   end

endmodule

// File: rtl/srt_csa_step.sv
module srt_csa_step
   import srt_pkg::*;
#(
   parameter int FRAC_W = 16,
   parameter int VEC_W  = FRAC_W + 3
) (
   input  logic [VEC_W-1:0]  dbl_sum,
   input  logic [VEC_W-1:0]  dbl_carry,
   input  logic [FRAC_W-1:0] divisor,
   input  srt_digit_e        digit,
   output logic [VEC_W-1:0]  nxt_sum,
   output logic [VEC_W-1:0]  nxt_carry
);
   localparam int PAD_W = VEC_W - FRAC_W;

   logic [VEC_W-1:0] div_ext;
   logic [VEC_W-1:0] multiple;
   logic [VEC_W-1:0] maj;
   logic             inject;

   assign div_ext = {{PAD_W{1'b0}}, divisor};

   // divisor multiple: +Y for digit -1, ~Y (plus injected 1) for digit +1
   always_comb begin
      unique case (digit)
         DIG_NEG: multiple = div_ext;
         DIG_POS: multiple = ~div_ext;
         default: multiple = '0;
      endcase
   end

   assign inject = (digit == DIG_POS);

   for (genvar b = 0; b < VEC_W; b++) begin : g_cell
      assign nxt_sum[b] = dbl_sum[b] ^ dbl_carry[b] ^ multiple[b];
      assign maj[b]     = (dbl_sum[b] & dbl_carry[b]) |
                          (dbl_sum[b] & multiple[b])  |
                          (dbl_carry[b] & multiple[b]);
   end

   assign nxt_carry = {maj[VEC_W-2:0], inject};

endmodule

// File: rtl/srt_rem_sign.sv
module srt_rem_sign #(
   parameter int VEC_W = 19
) (
   input  logic [VEC_W-1:0] vec_a,
   input  logic [VEC_W-1:0] vec_b,
   output logic             is_neg
);
   logic [VEC_W-1:0] total;

   assign total  = vec_a + vec_b;
   assign is_neg = total[VEC_W-1];

endmodule

// File: rtl/srt_cs_divider.sv
module srt_cs_divider
   import srt_pkg::*;
#(
   parameter int FRAC_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FRAC_W-1:0] x_in,
   input  logic [FRAC_W-1:0] y_in,
   output logic              q_valid,
   output logic [1:0]        q_digit,
   output logic [FRAC_W+2:0] rem_sum,
   output logic [FRAC_W+2:0] rem_carry,
   output logic              done,
   output logic              rem_neg
);
   localparam int VEC_W = FRAC_W + 3;
   localparam int CNT_W = $clog2(FRAC_W + 1);
   localparam int PAD_W = VEC_W - FRAC_W;

   if (FRAC_W < 4) begin : g_bad_width
      $error("FRAC_W must be at least 4");
   end

   srt_state_e        state;
   logic [CNT_W-1:0]  step_cnt;
   logic [FRAC_W-1:0] div_q;
   logic [VEC_W-1:0]  r_sum, r_carry;
   logic [VEC_W-1:0]  dbl_sum, dbl_carry;
   logic [VEC_W-1:0]  nxt_sum, nxt_carry;
   srt_digit_e        sel;
   logic              neg_now;

   assign dbl_sum   = {r_sum[VEC_W-2:0], 1'b0};
   assign dbl_carry = {r_carry[VEC_W-2:0], 1'b0};

   srt_digit_select #(.FRAC_W(FRAC_W), .VEC_W(VEC_W)) u_sel (
      .dbl_sum   (dbl_sum),
      .dbl_carry (dbl_carry),
      .digit     (sel)
   );

   srt_csa_step #(.FRAC_W(FRAC_W), .VEC_W(VEC_W)) u_step (
      .dbl_sum   (dbl_sum),
      .dbl_carry (dbl_carry),
      .divisor   (div_q),
      .digit     (sel),
      .nxt_sum   (nxt_sum),
      .nxt_carry (nxt_carry)
   );

   srt_rem_sign #(.VEC_W(VEC_W)) u_sign (
      .vec_a  (r_sum),
      .vec_b  (r_carry),
      .is_neg (neg_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         step_cnt <= '0;
         div_q    <= '0;
         r_sum    <= '0;
         r_carry  <= '0;
         q_valid  <= 1'b0;
         q_digit  <= DIG_ZERO;
         done     <= 1'b0;
         rem_neg  <= 1'b0;
      end else begin
         q_valid <= 1'b0;
         q_digit <= DIG_ZERO;
         done    <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  r_sum    <= {{PAD_W{1'b0}}, x_in};
                  r_carry  <= '0;
                  div_q    <= y_in;
                  step_cnt <= '0;
                  rem_neg  <= 1'b0;
                  state    <= ST_RUN;
               end
            end
            ST_RUN: begin
               r_sum    <= nxt_sum;
               r_carry  <= nxt_carry;
               q_valid  <= 1'b1;
               q_digit  <= sel;
               step_cnt <= step_cnt + 1'b1;
               if (step_cnt == CNT_W'(FRAC_W - 1))
                  state <= ST_FIN;
            end
            ST_FIN: begin
               done    <= 1'b1;
               rem_neg <= neg_now;
               state   <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign rem_sum   = r_sum;
   assign rem_carry = r_carry;

   // ---------------- assertions ----------------
   logic [VEC_W-1:0]        rem_val;
   logic [VEC_W-1:0]        step_ref;
   logic signed [VEC_W-1:0] y_s;

   assign rem_val = r_sum + r_carry;
   assign y_s     = $signed({{PAD_W{1'b0}}, div_q});

   always_comb begin
      unique case (sel)
         DIG_POS: step_ref = (rem_val << 1) - {{PAD_W{1'b0}}, div_q};
         DIG_NEG: step_ref = (rem_val << 1) + {{PAD_W{1'b0}}, div_q};
         default: step_ref = rem_val << 1;
      endcase
   end

   a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start) |=> (rem_sum == {{PAD_W{1'b0}}, $past(x_in)} && rem_carry == '0));

   a_r2_digit_code: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |-> (q_digit != 2'b10));

   a_r4_update: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN) |=> (rem_val == $past(step_ref)));

   a_r5_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |-> ($signed(rem_val) >= -y_s && $signed(rem_val) < y_s));

   a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(q_valid) |-> done);

   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: tb/srt_cs_divider_test.sv
module srt_cs_divider_test;
   localparam int N = 16;
   localparam int W = N + 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [N-1:0] x_in = '0;
   logic [N-1:0] y_in = '0;
   logic         q_valid;
   logic [1:0]   q_digit;
   logic [W-1:0] rem_sum, rem_carry;
   logic         done;
   logic         rem_neg;

   srt_cs_divider #(.FRAC_W(N)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in),
      .q_valid(q_valid), .q_digit(q_digit), .rem_sum(rem_sum),
      .rem_carry(rem_carry), .done(done), .rem_neg(rem_neg)
   );

   always #10 clk = ~clk;

   int     n_checks = 0;
   int     n_fail = 0;
   bit     finished = 0;

   // reference model state
   longint mx, my;
   longint prev_val, q_acc;
   int     dig_cnt, done_cnt, cyc_since_start;
   int     first_valid_cyc;
   logic [W-1:0] prev_s, prev_c;
   bit     active = 0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint sgn(input longint v, input int bits);
      longint m;
      m = v & ((longint'(1) << bits) - 1);
      if (m >= (longint'(1) << (bits - 1))) m = m - (longint'(1) << bits);
      return m;
   endfunction

   function automatic int ref_digit(input logic [W-1:0] s, input logic [W-1:0] c);
      longint ds, dc, est;
      ds  = sgn(longint'(s) * 2, W) >>> (N - 1);
      dc  = sgn(longint'(c) * 2, W) >>> (N - 1);
      est = sgn(ds + dc, 4);
      if (est <= -2) return -1;
      if (est == -1) return 0;
      return 1;
   endfunction

   function automatic int decode(input logic [1:0] d);
      case (d)
         2'b01: return 1;
         2'b11: return -1;
         2'b00: return 0;
         default: return 99;
      endcase
   endfunction

   // cycle-by-cycle comparison, sampled at the falling edge
   always @(negedge clk) begin
      longint cur_val, exp_val;
      int     qd, qe;
      if (rst_n && active) begin
         cyc_since_start++;
         cur_val = sgn(longint'(rem_sum) + longint'(rem_carry), W);
         if (q_valid) begin
            qd = decode(q_digit);
            qe = ref_digit(prev_s, prev_c);
            if (dig_cnt == 0) first_valid_cyc = cyc_since_start;
            check(qd == qe, "R3 digit selection", qd, qe);
            check(qd != 99, "R2 digit code", q_digit, 1);
            exp_val = 2 * prev_val - longint'(qe) * my;
            check(cur_val == exp_val, "R4 remainder update", cur_val, exp_val);
            check(cur_val >= -my && cur_val < my, "R5 remainder bound", cur_val, my);
            q_acc = q_acc * 2 + qd;
            dig_cnt++;
         end else if (!done) begin
            check(q_digit == 2'b00, "R2 idle digit", q_digit, 0);
         end
         if (done) begin
            check(dig_cnt == N, "R6 digit count", dig_cnt, N);
            check(first_valid_cyc == 2, "R6 first digit cycle", first_valid_cyc, 2);
            check(rem_neg == (cur_val < 0), "R7 sign flag", rem_neg, cur_val < 0);
            check((mx << N) == q_acc * my + cur_val, "R8 identity",
                  q_acc * my + cur_val, mx << N);
            check(!q_valid, "R7 done after last digit", q_valid, 0);
            done_cnt++;
            active = 0;
         end
         prev_val = cur_val;
      end
      prev_s = rem_sum;
      prev_c = rem_carry;
   end

   task automatic run(input logic [N-1:0] xv, input logic [N-1:0] yv, input int poke_at);
      int base;
      @(negedge clk);
      mx = xv; my = yv;
      prev_val = xv; q_acc = 0; dig_cnt = 0; cyc_since_start = 0; first_valid_cyc = -1;
      base = done_cnt;
      x_in = xv; y_in = yv; start = 1'b1;
      @(negedge clk);
      active = 1;
      start = 1'b0;
      x_in = ~xv; y_in = ~yv;
      check(rem_sum == W'(xv) && rem_carry == '0, "R1 load", rem_sum, xv);
      check(!q_valid, "R1 no digit at load", q_valid, 0);
      for (int k = 0; k < 3 * N && done_cnt == base; k++) begin
         if (k == poke_at) begin
            x_in = N'(xv + 1); y_in = 16'hFFFF; start = 1'b1;   // R9 stray start
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      check(done_cnt == base + 1, "R9 completion", done_cnt, base + 1);
      @(negedge clk);
      check(!done, "R7 done one cycle", done, 0);
      check(rem_neg == (prev_val < 0), "R7 flag held", rem_neg, prev_val < 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] a, b, t;
      int lfsr;
      repeat (3) @(negedge clk);
      check(!q_valid && !done && !rem_neg && rem_sum == '0 && rem_carry == '0,
            "R10 reset state", {q_valid, done, rem_neg}, 0);
      rst_n = 1'b1;
      run(16'h8000, 16'h8001, -1);
      run(16'h8000, 16'hFFFF, -1);
      run(16'hFFFE, 16'hFFFF, -1);
      run(16'hA000, 16'hC000, -1);
      run(16'hC000, 16'hC001, 5);     // R9 stray start mid-run
      run(16'h9999, 16'hF0F0, N - 1); // R9 stray start on last step
      lfsr = 32'h1ACE;
      for (int i = 0; i < 12; i++) begin
         lfsr = (lfsr * 1103515245 + 12345) & 32'h7FFFFFFF;
         a = N'(lfsr) | 16'h8000;
         lfsr = (lfsr * 1103515245 + 12345) & 32'h7FFFFFFF;
         b = N'(lfsr >> 3) | 16'h8000;
         if (a == b) b = b ^ 16'h0001;
         if (a > b) begin t = a; a = b; b = t; end
         run(a, b, (i % 3 == 0) ? i : -1);
      end
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule